// File: doc/BRIEF.md
# Rotary-Knob Decimal Frequency Editor

This block holds a nine-digit decimal frequency, 0 Hz to 999 999 999 Hz in 1 Hz steps, and lets an operator change it with one rotary knob that has a push switch. It takes knob events that are already decoded: a one-cycle pulse for each step to the left, one for each step to the right, and one for each completed press-and-release. It drives a display with the BCD digits, the cursor position, per-digit blanking flags and a pair of mode LEDs. It also raises a one-cycle pulse whenever the value changes, so that a downstream synthesizer can follow each step at once.

The block has two modes. In cursor mode the knob moves an underline from digit to digit. The display column it reports skips the decimal point and the thousands space, and the cursor stops at both ends. In digit mode the knob raises or lowers the digit under the cursor. A carry or borrow ripples into the higher digits. An edit that would take the value below zero or above nine nines is refused. The two highest digits are leading-zero blanked, but the cursor may still rest on them.

Top module: `freq_knob_editor`

## Requirements
- R1: After a synchronous reset the value is 010 000 000 (digit 7 = 1, all others 0), the cursor index is 0 (the 1 Hz digit), the mode is cursor mode, and changed_o is 0.
- R2: Each push_i pulse toggles the mode. mode_led_o is 2'b01 in cursor mode and 2'b10 in digit mode.
- R3: In cursor mode a rot_left_i step raises the cursor index by one (toward more significant digits) and a rot_right_i step lowers it by one. Index i selects digit i, where digit 0 is the 1 Hz digit.
- R4: The cursor index saturates at 0 and at 8. A step past either end leaves it unchanged.
- R5: cursor_col_o equals (8-i) + (8-i)/3 for cursor index i, counting columns from 0 at the leftmost digit. Columns 3 and 7 hold separators and are never reported.
- R6: In digit mode a rot_right_i step adds one unit of the cursor digit to the value. A digit passing 9 wraps to 0 and carries into the next higher digit.
- R7: In digit mode a rot_left_i step subtracts one unit of the cursor digit. A digit passing 0 wraps to 9 and borrows from the next higher digit.
- R8: An edit whose result would be below 0 or above 999 999 999 is ignored. The value is left unchanged and no changed_o pulse is raised.
- R9: changed_o is high for exactly the one cycle after each applied edit. It stays low after cursor moves, mode toggles and refused edits.
- R10: blank_o[8] is 1 when digit 8 is 0. blank_o[7] is 1 when digits 8 and 7 are both 0. blank_o[6:0] are always 0.
- R11: A push_i in the same cycle as a rotation step toggles the mode and discards the step. A rot_left_i and rot_right_i in the same cycle cancel each other, and nothing changes.
- R12: In cursor mode the digits never change. In digit mode the cursor never moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rot_left_i | input | 1 | One-cycle pulse per left knob step |
| rot_right_i | input | 1 | One-cycle pulse per right knob step |
| push_i | input | 1 | One-cycle pulse per press-and-release |
| digits_o | output | 36 | BCD digits, digit i in bits 4i+3:4i, digit 0 = 1 Hz |
| cursor_o | output | 4 | Cursor digit index |
| cursor_col_o | output | 4 | Cursor display column, separators skipped |
| blank_o | output | 9 | Per-digit blanking flags |
| mode_led_o | output | 2 | Mode pattern, 01 cursor, 10 digit |
| changed_o | output | 1 | One-cycle pulse after each applied edit |

## Verification
The functions that can meet in one cycle are the mode toggle and a rotation step, and the two opposite rotation steps with each other. The bench drives push_i together with rot_right_i in digit mode and together with rot_left_i in cursor mode. It then checks that only the mode flipped: the cursor, the digits and changed_o keep their previous values. It also drives both rotation inputs at once in each mode and expects no change at all.

// File: rtl/fe_pkg.sv
package fe_pkg;

    typedef enum logic {
        MODE_CURSOR = 1'b0,
        MODE_EDIT   = 1'b1
    } edit_mode_e;

    typedef struct packed {
        logic toggle;
        logic move;
        logic edit;
        logic up;
    } knob_action_t;

    function automatic logic [1:0] led_pattern(edit_mode_e m);
        return (m == MODE_EDIT) ? 2'b10 : 2'b01;
    endfunction

    // Column of digit idx, leftmost digit at column 0, one separator per group.
    function automatic int unsigned digit_column(int unsigned idx,
                                                 int unsigned ndig,
                                                 int unsigned grp);
        int unsigned rev;
        rev = ndig - 1 - idx;
        return rev + rev / grp;
    endfunction

endpackage

// File: rtl/fe_cursor.sv
module fe_cursor #(
    parameter int NUM_DIGITS = 9,
    parameter int IDX_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             move_i,
    input  logic             toward_msd_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_DIGITS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_o <= '0;
        end else if (move_i) begin
            if (toward_msd_i && idx_o != TOP_IDX) begin
                idx_o <= idx_o + 1'b1;
            end else if (!toward_msd_i && idx_o != '0) begin
                idx_o <= idx_o - 1'b1;
            end
        end
    end
endmodule

// File: rtl/fe_digit_alu.sv
module fe_digit_alu #(
    parameter int NUM_DIGITS = 9,
    parameter int IDX_W      = 4
) (
    input  logic [NUM_DIGITS*4-1:0] digits_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    up_i,
    output logic [NUM_DIGITS*4-1:0] digits_o,
    output logic                    out_of_range_o
);
    logic [NUM_DIGITS:0] ripple;
    assign ripple[0] = 1'b0;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        logic [3:0] cur;
        logic       unit;
        logic [4:0] t;
        logic [3:0] res;
        logic       cout;

        assign cur  = digits_i[4*i +: 4];
        assign unit = (idx_i == IDX_W'(i));

        always_comb begin
            if (up_i) begin
                t = {1'b0, cur} + 5'(unit) + 5'(ripple[i]);
                if (t > 5'd9) begin
                    res  = 4'(t - 5'd10);
                    cout = 1'b1;
                end else begin
                    res  = t[3:0];
                    cout = 1'b0;
                end
            end else begin
                t = {1'b0, cur} - 5'(unit) - 5'(ripple[i]);
                if (t[4]) begin
                    res  = 4'(t + 5'd10);
                    cout = 1'b1;
                end else begin
                    res  = t[3:0];
                    cout = 1'b0;
                end
            end
        end

        assign digits_o[4*i +: 4] = res;
        assign ripple[i+1]        = cout;
    end

    assign out_of_range_o = ripple[NUM_DIGITS];
endmodule

// File: rtl/fe_blank.sv
module fe_blank #(
    parameter int NUM_DIGITS = 9,
    parameter int BLANK_TOP  = 2
) (
    input  logic [NUM_DIGITS*4-1:0] digits_i,
    output logic [NUM_DIGITS-1:0]   blank_o
);
    logic [NUM_DIGITS:0] lead_zero;
    assign lead_zero[NUM_DIGITS] = 1'b1;

    for (genvar i = NUM_DIGITS - 1; i >= 0; i--) begin : g_bl
        assign lead_zero[i] = lead_zero[i+1] & (digits_i[4*i +: 4] == 4'd0);
        if (i >= NUM_DIGITS - BLANK_TOP) begin : g_top
            assign blank_o[i] = lead_zero[i];
        end else begin : g_low
            assign blank_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/freq_knob_editor.sv
module freq_knob_editor
    import fe_pkg::*;
#(
    parameter int                      NUM_DIGITS = 9,
    parameter int                      GROUP      = 3,
    parameter int                      BLANK_TOP  = 2,
    parameter logic [NUM_DIGITS*4-1:0] RESET_BCD  = 36'h0_1000_0000
) (
    input  logic                                                  clk,
    input  logic                                                  rst,
    input  logic                                                  rot_left_i,
    input  logic                                                  rot_right_i,
    input  logic                                                  push_i,
    output logic [NUM_DIGITS*4-1:0]                               digits_o,
    output logic [$clog2(NUM_DIGITS)-1:0]                         cursor_o,
    output logic [$clog2(NUM_DIGITS + (NUM_DIGITS-1)/GROUP)-1:0]  cursor_col_o,
    output logic [NUM_DIGITS-1:0]                                 blank_o,
    output logic [1:0]                                            mode_led_o,
    output logic                                                  changed_o
);
    localparam int IDX_W    = $clog2(NUM_DIGITS);
    localparam int NUM_COLS = NUM_DIGITS + (NUM_DIGITS - 1) / GROUP;
    localparam int COL_W    = $clog2(NUM_COLS);

    edit_mode_e              mode_q;
    logic [NUM_DIGITS*4-1:0] value_q;
    logic [NUM_DIGITS*4-1:0] value_next;
    logic                    refused;
    logic                    changed_q;
    knob_action_t            act;

    // Push wins over rotation; opposite steps in one cycle cancel.
    always_comb begin
        act.toggle = push_i;
        act.move   = !push_i && (rot_left_i ^ rot_right_i) && (mode_q == MODE_CURSOR);
        act.edit   = !push_i && (rot_left_i ^ rot_right_i) && (mode_q == MODE_EDIT);
        act.up     = rot_right_i;
    end

    fe_cursor #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) cursor_u (
        .clk          (clk),
        .rst          (rst),
        .move_i       (act.move),
        .toward_msd_i (rot_left_i),
        .idx_o        (cursor_o)
    );

    fe_digit_alu #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IDX_W)) alu_u (
        .digits_i       (value_q),
        .idx_i          (cursor_o),
        .up_i           (act.up),
        .digits_o       (value_next),
        .out_of_range_o (refused)
    );

    fe_blank #(.NUM_DIGITS(NUM_DIGITS), .BLANK_TOP(BLANK_TOP)) blank_u (
        .digits_i (value_q),
        .blank_o  (blank_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_CURSOR;
            value_q   <= RESET_BCD;
            changed_q <= 1'b0;
        end else begin
            changed_q <= act.edit && !refused;
            if (act.toggle) begin
                mode_q <= (mode_q == MODE_CURSOR) ? MODE_EDIT : MODE_CURSOR;
            end
            if (act.edit && !refused) begin
                value_q <= value_next;
            end
        end
    end

    always_comb begin
        cursor_col_o = '0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (cursor_o == IDX_W'(i)) begin
                cursor_col_o = COL_W'(digit_column(i, NUM_DIGITS, GROUP));
            end
        end
    end

    assign digits_o   = value_q;
    assign mode_led_o = led_pattern(mode_q);
    assign changed_o  = changed_q;
endmodule

// File: rtl/fe_editor_chk.sv
module fe_editor_chk #(
    parameter int NUM_DIGITS = 9,
    parameter int IDX_W      = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    rot_left_i,
    input logic                    rot_right_i,
    input logic                    push_i,
    input logic [NUM_DIGITS*4-1:0] digits_o,
    input logic [IDX_W-1:0]        cursor_o,
    input logic [1:0]              mode_led_o,
    input logic                    changed_o
);
    // R2
    mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(mode_led_o) == 1);

    // R2
    press_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |=> (mode_led_o != $past(mode_led_o)));

    // R4
    cursor_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(cursor_o) < NUM_DIGITS);

    // R9
    changed_cause_chk: assert property (@(posedge clk) disable iff (rst)
        changed_o |-> ($past(rot_left_i ^ rot_right_i) && !$past(push_i)
                       && $past(mode_led_o) == 2'b10));

    // R12
    cursor_mode_value_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_led_o == 2'b01) |=> $stable(digits_o));

    // R12
    edit_mode_cursor_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_led_o == 2'b10) |=> $stable(cursor_o));

    // R11
    opposite_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (rot_left_i && rot_right_i) |=> ($stable(cursor_o) && $stable(digits_o)));

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dchk
        // R6 R7
        digit_legal_chk: assert property (@(posedge clk) disable iff (rst)
            digits_o[4*i +: 4] <= 4'd9);
    end
endmodule

bind freq_knob_editor fe_editor_chk #(
    .NUM_DIGITS (NUM_DIGITS),
    .IDX_W      ($clog2(NUM_DIGITS))
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .rot_left_i  (rot_left_i),
    .rot_right_i (rot_right_i),
    .push_i      (push_i),
    .digits_o    (digits_o),
    .cursor_o    (cursor_o),
    .mode_led_o  (mode_led_o),
    .changed_o   (changed_o)
);

// File: tb/freq_knob_editor_tb_top.sv
module freq_knob_editor_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rot_left_i = 1'b0;
    logic        rot_right_i = 1'b0;
    logic        push_i = 1'b0;
    logic [35:0] digits_o;
    logic [3:0]  cursor_o;
    logic [3:0]  cursor_col_o;
    logic [8:0]  blank_o;
    logic [1:0]  mode_led_o;
    logic        changed_o;

    int errors = 0;
    int checks = 0;

    longint exp_val = 10000000;
    int     exp_cur = 0;
    bit     exp_edit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_knob_editor dut_i (
        .clk          (clk),
        .rst          (rst),
        .rot_left_i   (rot_left_i),
        .rot_right_i  (rot_right_i),
        .push_i       (push_i),
        .digits_o     (digits_o),
        .cursor_o     (cursor_o),
        .cursor_col_o (cursor_col_o),
        .blank_o      (blank_o),
        .mode_led_o   (mode_led_o),
        .changed_o    (changed_o)
    );

    function automatic longint bcd_value(logic [35:0] d);
        longint v = 0;
        for (int i = 8; i >= 0; i--) v = v * 10 + longint'(d[4*i +: 4]);
        return v;
    endfunction

    function automatic longint pow10(int k);
        longint p = 1;
        for (int i = 0; i < k; i++) p = p * 10;
        return p;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(string req, bit exp_chg);
        longint d8;
        longint d7;
        longint bl;
        d8 = exp_val / 100000000;
        d7 = (exp_val / 10000000) % 10;
        bl = ((d8 == 0) ? 2 : 0) + ((d8 == 0 && d7 == 0) ? 1 : 0);
        check({req, " R6 R7 R8 value"}, bcd_value(digits_o), exp_val);
        check({req, " R3 R4 cursor"}, longint'(cursor_o), longint'(exp_cur));
        check({req, " R5 column"}, longint'(cursor_col_o),
              longint'((8 - exp_cur) + (8 - exp_cur) / 3));
        check({req, " R2 leds"}, longint'(mode_led_o), exp_edit ? 2 : 1);
        check({req, " R10 blank"}, longint'(blank_o), bl << 7);
        check({req, " R9 changed"}, longint'(changed_o), longint'(exp_chg));
    endtask

    // One knob event; model from the requirements, then check the outputs.
    task automatic step(bit l, bit r, bit p, string req);
        bit chg = 1'b0;
        rot_left_i  = l;
        rot_right_i = r;
        push_i      = p;
        if (p) begin
            exp_edit = !exp_edit;
        end else if (l ^ r) begin
            if (!exp_edit) begin
                if (l && exp_cur < 8) exp_cur++;
                else if (r && exp_cur > 0) exp_cur--;
            end else begin
                longint nv;
                nv = r ? exp_val + pow10(exp_cur) : exp_val - pow10(exp_cur);
                if (nv >= 0 && nv <= 999999999) begin
                    exp_val = nv;
                    chg = 1'b1;
                end
            end
        end
        @(negedge clk);
        rot_left_i  = 1'b0;
        rot_right_i = 1'b0;
        push_i      = 1'b0;
        check_all(req, chg);
        @(negedge clk);
        check({req, " R9 pulse ends"}, longint'(changed_o), 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 reset", 1'b0);
    endtask

    task automatic t_cursor();
        step(0, 1, 0, "R4 right end stop");
        for (int i = 0; i < 9; i++) step(1, 0, 0, "R3 R4 R5 move left");
        for (int i = 0; i < 8; i++) step(0, 1, 0, "R3 R5 move right");
        step(1, 1, 0, "R11 opposite steps in cursor mode");
    endtask

    task automatic t_edit();
        step(0, 0, 1, "R2 enter digit mode");
        for (int i = 0; i < 10; i++) step(0, 1, 0, "R6 R12 increment carry");
        for (int i = 0; i < 11; i++) step(1, 0, 0, "R7 R10 decrement borrow");
        step(1, 1, 0, "R11 opposite steps in digit mode");
    endtask

    task automatic t_limits();
        step(0, 0, 1, "R2 back to cursor mode");
        for (int i = 0; i < 8; i++) step(1, 0, 0, "R3 to top digit");
        step(0, 0, 1, "R2 digit mode at top");
        step(1, 0, 0, "R8 borrow below zero refused");
        for (int i = 0; i < 10; i++) step(0, 1, 0, "R8 R10 top increments, last refused");
    endtask

    task automatic t_same_cycle();
        step(0, 1, 1, "R11 push with right in digit mode");
        step(1, 0, 1, "R11 push with left in cursor mode");
        step(0, 0, 1, "R2 toggle again");
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_cursor();
        t_edit();
        t_limits();
        t_same_cycle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule